// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer and the invalid-window mask for a processor whose register file is split into a configurable number of overlapping windows. It also holds the processor mode bits that go with window movement: enable-traps, supervisor, previous-supervisor, enable-FPU and the interrupt priority level. The execute stage sends it single-cycle command pulses: save (move one window down), restore (move one window up), return-from-trap, and status-word write.

For each command the block works out the target window modulo the window count and tests the mask bit for that window. It then either commits the move or emits a one-cycle trap pulse with an 8-bit trap type, leaving the pointer where it was. Trap vectoring, the physical register file and interrupt arbitration sit outside this block. They consume `trap_valid`/`trap_type` and the pointer. The mask register is loaded through its own write port.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the mask is 0, supervisor is 1, and enable-traps, previous-supervisor, enable-FPU, the priority level and `trap_valid` are all 0.
- R2: A save with the mask bit clear at the target moves the pointer to pointer-1. From 0 it wraps to NWIN-1.
- R3: A restore with the mask bit clear at the target moves the pointer to pointer+1. From NWIN-1 it wraps to 0.
- R4: If the target mask bit is set, a save raises trap type 0x05 and a restore raises trap type 0x06. In both cases the pointer is unchanged.
- R5: A return-from-trap issued while enable-traps is 1 raises trap type 0x02 and changes no state.
- R6: A return-from-trap issued while enable-traps is 0 first sets enable-traps to 1. It then steps the pointer up with wrap. On success it copies previous-supervisor into supervisor. If the mask bit at the target is set, it raises trap type 0x06 instead, keeps the pointer and keeps supervisor, but enable-traps stays 1.
- R7: A status write whose pointer field (bits 4:0) is NWIN or more raises trap type 0x02 and changes no state.
- R8: A valid status write loads the pointer from bits 4:0, enable-traps from bit 5, previous-supervisor from bit 6, supervisor from bit 7, the priority level from bits 11:8 and enable-FPU from bit 12. `status_word` reads back the same layout with all other bits 0.
- R9: `trap_valid` is high only in the cycle after an offending command. `trap_type` is 0 whenever `trap_valid` is 0.
- R10: `mask_we` loads the mask on the next edge. A command in the same cycle is checked against the previous mask.
- R11: When several command pulses arrive together, only one is performed, in the priority order status write, return-from-trap, restore, save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_save | input | 1 | Save pulse (move down one window) |
| cmd_restore | input | 1 | Restore pulse (move up one window) |
| cmd_rett | input | 1 | Return-from-trap pulse |
| cmd_wrstat | input | 1 | Status-word write pulse |
| wr_status | input | 32 | Data for the status-word write |
| mask_we | input | 1 | Invalid-window mask write enable |
| mask_wdata | input | NWIN | New mask value |
| cwp | output | CWP_W | Current window pointer |
| wim | output | NWIN | Invalid-window mask, one bit per window |
| et | output | 1 | Enable-traps bit |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous-supervisor bit |
| status_word | output | 32 | Assembled status word |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_type | output | 8 | Trap type code, 0 when no trap |

## Verification
The per-command properties assume that a command arrives as the only pulse in its cycle. Each one is qualified on exactly one command line being high, so the arbitration cycles fall outside them. The mask and status data are taken as arbitrary values. The stimulus keeps to single pulses everywhere except the few directed priority cases, which only the bench's own checks judge. The "no trap when idle" property assumes that no command is pending. The bench always drops every command line in the cycle after it drives one.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam int STAT_W     = 32;
   localparam int CWP_FLD_W  = 5;
   localparam int PIL_W      = 4;
   localparam int TT_W       = 8;

   localparam int STB_ET     = 5;
   localparam int STB_PS     = 6;
   localparam int STB_S      = 7;
   localparam int STB_PIL_LO = 8;
   localparam int STB_EF     = 12;

   localparam logic [TT_W-1:0] TT_NONE    = 8'h00;
   localparam logic [TT_W-1:0] TT_ILLEGAL = 8'h02;
   localparam logic [TT_W-1:0] TT_WOVF    = 8'h05;
   localparam logic [TT_W-1:0] TT_WUNF    = 8'h06;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_SAVE,
      OP_RESTORE,
      OP_RETT,
      OP_WRSTAT
   } op_e;

   typedef struct packed {
      logic             ef;
      logic [PIL_W-1:0] pil;
      logic             sup;
      logic             prev_sup;
      logic             et;
   } mode_t;

   localparam mode_t MODE_RST = '{ef: 1'b0, pil: '0, sup: 1'b1, prev_sup: 1'b0, et: 1'b0};

endpackage

// File: rtl/regwin_op_sel.sv
module regwin_op_sel
   import regwin_pkg::*;
(
   input  logic cmd_save,
   input  logic cmd_restore,
   input  logic cmd_rett,
   input  logic cmd_wrstat,
   output op_e  op
);

   always_comb begin
      if (cmd_wrstat)       op = OP_WRSTAT;
      else if (cmd_rett)    op = OP_RETT;
      else if (cmd_restore) op = OP_RESTORE;
      else if (cmd_save)    op = OP_SAVE;
      else                  op = OP_IDLE;
   end

endmodule

// File: rtl/regwin_ptr_step.sv
module regwin_ptr_step #(
   parameter int NWIN  = 8,
   parameter int CWP_W = 3
) (
   input  logic [CWP_W-1:0] cur,
   output logic [CWP_W-1:0] dec,
   output logic [CWP_W-1:0] inc
);

   localparam bit IS_POW2 = ((NWIN & (NWIN - 1)) == 0);
   localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);
   localparam logic [CWP_W-1:0] ONE = CWP_W'(1);

   generate
      if (IS_POW2) begin : g_pow2
         assign dec = cur - ONE;
         assign inc = cur + ONE;
      end else begin : g_cmp
         assign dec = (cur == '0)  ? TOP : (cur - ONE);
         assign inc = (cur == TOP) ? '0  : (cur + ONE);
      end
   endgenerate

endmodule

// File: rtl/regwin_decide.sv
module regwin_decide
   import regwin_pkg::*;
#(
   parameter int NWIN  = 8,
   parameter int CWP_W = 3
) (
   input  op_e               op,
   input  logic [CWP_W-1:0]  cwp,
   input  logic [CWP_W-1:0]  dec,
   input  logic [CWP_W-1:0]  inc,
   input  logic [NWIN-1:0]   wim,
   input  mode_t             mode,
   input  logic [STAT_W-1:0] wr_data,
   output logic [CWP_W-1:0]  nxt_cwp,
   output logic              cwp_ld,
   output mode_t             nxt_mode,
   output logic              mode_ld,
   output logic              trap,
   output logic [TT_W-1:0]   ttype
);

   localparam logic [CWP_FLD_W:0] LIMIT = (CWP_FLD_W+1)'(NWIN);

   logic                 fld_bad;
   logic                 dec_blocked;
   logic                 inc_blocked;
   mode_t                wr_mode;

   assign fld_bad     = ({1'b0, wr_data[CWP_FLD_W-1:0]} >= LIMIT);
   assign dec_blocked = wim[dec];
   assign inc_blocked = wim[inc];

   always_comb begin
      wr_mode.ef       = wr_data[STB_EF];
      wr_mode.pil      = wr_data[STB_PIL_LO +: PIL_W];
      wr_mode.sup      = wr_data[STB_S];
      wr_mode.prev_sup = wr_data[STB_PS];
      wr_mode.et       = wr_data[STB_ET];
   end

   always_comb begin
      nxt_cwp  = cwp;
      cwp_ld   = 1'b0;
      nxt_mode = mode;
      mode_ld  = 1'b0;
      trap     = 1'b0;
      ttype    = TT_NONE;
      case (op)
         OP_SAVE: begin
            if (dec_blocked) begin
               trap  = 1'b1;
               ttype = TT_WOVF;
            end else begin
               nxt_cwp = dec;
               cwp_ld  = 1'b1;
            end
         end
         OP_RESTORE: begin
            if (inc_blocked) begin
               trap  = 1'b1;
               ttype = TT_WUNF;
            end else begin
               nxt_cwp = inc;
               cwp_ld  = 1'b1;
            end
         end
         OP_RETT: begin
            if (mode.et) begin
               trap  = 1'b1;
               ttype = TT_ILLEGAL;
            end else begin
               mode_ld     = 1'b1;
               nxt_mode.et = 1'b1;
               if (inc_blocked) begin
                  trap  = 1'b1;
                  ttype = TT_WUNF;
               end else begin
                  nxt_cwp      = inc;
                  cwp_ld       = 1'b1;
                  nxt_mode.sup = mode.prev_sup;
               end
            end
         end
         OP_WRSTAT: begin
            if (fld_bad) begin
               trap  = 1'b1;
               ttype = TT_ILLEGAL;
            end else begin
               nxt_cwp  = wr_data[CWP_W-1:0];
               cwp_ld   = 1'b1;
               nxt_mode = wr_mode;
               mode_ld  = 1'b1;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter int NWIN = 8,
   localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_save,
   input  logic              cmd_restore,
   input  logic              cmd_rett,
   input  logic              cmd_wrstat,
   input  logic [31:0]       wr_status,
   input  logic              mask_we,
   input  logic [NWIN-1:0]   mask_wdata,
   output logic [CWP_W-1:0]  cwp,
   output logic [NWIN-1:0]   wim,
   output logic              et,
   output logic              sup,
   output logic              prev_sup,
   output logic [31:0]       status_word,
   output logic              trap_valid,
   output logic [7:0]        trap_type
);

   generate
      if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
         $error("regwin_ctrl: NWIN must lie in 2..32");
      end
   endgenerate

   op_e               op;
   logic [CWP_W-1:0]  cwp_q;
   logic [CWP_W-1:0]  dec;
   logic [CWP_W-1:0]  inc;
   logic [NWIN-1:0]   wim_q;
   mode_t             mode_q;
   logic [CWP_W-1:0]  nxt_cwp;
   logic              cwp_ld;
   mode_t             nxt_mode;
   logic              mode_ld;
   logic              trap_d;
   logic [TT_W-1:0]   ttype_d;
   logic              trap_q;
   logic [TT_W-1:0]   ttype_q;

   regwin_op_sel u_sel (
      .cmd_save    (cmd_save),
      .cmd_restore (cmd_restore),
      .cmd_rett    (cmd_rett),
      .cmd_wrstat  (cmd_wrstat),
      .op          (op)
   );

   regwin_ptr_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_step (
      .cur (cwp_q),
      .dec (dec),
      .inc (inc)
   );

   regwin_decide #(.NWIN(NWIN), .CWP_W(CWP_W)) u_dec (
      .op       (op),
      .cwp      (cwp_q),
      .dec      (dec),
      .inc      (inc),
      .wim      (wim_q),
      .mode     (mode_q),
      .wr_data  (wr_status),
      .nxt_cwp  (nxt_cwp),
      .cwp_ld   (cwp_ld),
      .nxt_mode (nxt_mode),
      .mode_ld  (mode_ld),
      .trap     (trap_d),
      .ttype    (ttype_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q   <= '0;
         wim_q   <= '0;
         mode_q  <= MODE_RST;
         trap_q  <= 1'b0;
         ttype_q <= TT_NONE;
      end else begin
         if (cwp_ld)  cwp_q  <= nxt_cwp;
         if (mode_ld) mode_q <= nxt_mode;
         if (mask_we) wim_q  <= mask_wdata;
         trap_q  <= trap_d;
         ttype_q <= ttype_d;
      end
   end

   always_comb begin
      status_word                         = '0;
      status_word[CWP_W-1:0]              = cwp_q;
      status_word[STB_ET]                 = mode_q.et;
      status_word[STB_PS]                 = mode_q.prev_sup;
      status_word[STB_S]                  = mode_q.sup;
      status_word[STB_PIL_LO +: PIL_W]    = mode_q.pil;
      status_word[STB_EF]                 = mode_q.ef;
   end

   assign cwp        = cwp_q;
   assign wim        = wim_q;
   assign et         = mode_q.et;
   assign sup        = mode_q.sup;
   assign prev_sup   = mode_q.prev_sup;
   assign trap_valid = trap_q;
   assign trap_type  = ttype_q;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int NWIN  = 8,
   parameter int CWP_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_save,
   input logic             cmd_restore,
   input logic             cmd_rett,
   input logic             cmd_wrstat,
   input logic [31:0]      wr_status,
   input logic [CWP_W-1:0] cwp,
   input logic [NWIN-1:0]  wim,
   input logic             et,
   input logic             sup,
   input logic             trap_valid,
   input logic [7:0]       trap_type
);

   logic [CWP_W-1:0] down_w;
   logic [CWP_W-1:0] up_w;
   logic only_save, only_restore, only_rett, only_wr, none;

   assign down_w = CWP_W'((int'(cwp) + NWIN - 1) % NWIN);
   assign up_w   = CWP_W'((int'(cwp) + 1) % NWIN);

   assign only_save    = cmd_save & ~cmd_restore & ~cmd_rett & ~cmd_wrstat;
   assign only_restore = ~cmd_save & cmd_restore & ~cmd_rett & ~cmd_wrstat;
   assign only_rett    = ~cmd_save & ~cmd_restore & cmd_rett & ~cmd_wrstat;
   assign only_wr      = ~cmd_save & ~cmd_restore & ~cmd_rett & cmd_wrstat;
   assign none         = ~cmd_save & ~cmd_restore & ~cmd_rett & ~cmd_wrstat;

   a_r2_save_step: assert property (@(posedge clk) disable iff (!rst_n)
      only_save && !wim[down_w] |=> cwp == $past(down_w) && !trap_valid);

   a_r3_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
      only_restore && !wim[up_w] |=> cwp == $past(up_w) && !trap_valid);

   a_r4_save_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      only_save && wim[down_w] |=> trap_valid && trap_type == 8'h05 && cwp == $past(cwp));

   a_r4_restore_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      only_restore && wim[up_w] |=> trap_valid && trap_type == 8'h06 && cwp == $past(cwp));

   a_r5_rett_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      only_rett && et |=> trap_valid && trap_type == 8'h02 && cwp == $past(cwp) && et);

   a_r6_rett_enables: assert property (@(posedge clk) disable iff (!rst_n)
      only_rett && !et |=> et);

   a_r7_bad_field: assert property (@(posedge clk) disable iff (!rst_n)
      only_wr && ({1'b0, wr_status[4:0]} >= 6'(NWIN))
      |=> trap_valid && trap_type == 8'h02 && cwp == $past(cwp) && sup == $past(sup));

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      none |=> !trap_valid && trap_type == 8'h00);

endmodule

bind regwin_ctrl regwin_chk #(.NWIN(NWIN), .CWP_W(CWP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_save    (cmd_save),
   .cmd_restore (cmd_restore),
   .cmd_rett    (cmd_rett),
   .cmd_wrstat  (cmd_wrstat),
   .wr_status   (wr_status),
   .cwp         (cwp),
   .wim         (wim),
   .et          (et),
   .sup         (sup),
   .trap_valid  (trap_valid),
   .trap_type   (trap_type)
);

// File: tb/tb_regwin_ctrl.sv
module tb_regwin_ctrl;

   localparam int CLK_P = 10;
   localparam int NW    = 8;
   localparam int CW    = 3;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] data;
      logic [4:0]  cwp;
      logic        trap;
      logic [7:0]  tt;
      logic        et;
      logic        sup;
   } vec_t;

   // op: 1 save, 2 restore, 3 return-from-trap, 4 status write, 5 mask write
   localparam int NVEC = 17;
   localparam vec_t VEC [NVEC] = '{
      '{3'd1, 32'h0,    5'd7, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd1, 32'h0,    5'd6, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd2, 32'h0,    5'd7, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd2, 32'h0,    5'd0, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd5, 32'h80,   5'd0, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd1, 32'h0,    5'd0, 1'b1, 8'h05, 1'b0, 1'b1},
      '{3'd5, 32'h02,   5'd0, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd2, 32'h0,    5'd0, 1'b1, 8'h06, 1'b0, 1'b1},
      '{3'd4, 32'h09,   5'd0, 1'b1, 8'h02, 1'b0, 1'b1},
      '{3'd4, 32'h1583, 5'd3, 1'b0, 8'h00, 1'b0, 1'b1},
      '{3'd3, 32'h0,    5'd4, 1'b0, 8'h00, 1'b1, 1'b0},
      '{3'd3, 32'h0,    5'd4, 1'b1, 8'h02, 1'b1, 1'b0},
      '{3'd4, 32'h40,   5'd0, 1'b0, 8'h00, 1'b0, 1'b0},
      '{3'd3, 32'h0,    5'd0, 1'b1, 8'h06, 1'b1, 1'b0},
      '{3'd5, 32'h0,    5'd0, 1'b0, 8'h00, 1'b1, 1'b0},
      '{3'd4, 32'h47,   5'd7, 1'b0, 8'h00, 1'b0, 1'b0},
      '{3'd3, 32'h0,    5'd0, 1'b0, 8'h00, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_save = 1'b0, cmd_restore = 1'b0, cmd_rett = 1'b0, cmd_wrstat = 1'b0;
   logic [31:0]   wr_status = '0;
   logic          mask_we = 1'b0;
   logic [NW-1:0] mask_wdata = '0;
   logic [CW-1:0] cwp;
   logic [NW-1:0] wim;
   logic          et, sup, prev_sup;
   logic [31:0]   status_word;
   logic          trap_valid;
   logic [7:0]    trap_type;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   regwin_ctrl #(.NWIN(NW)) dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_save(cmd_save), .cmd_restore(cmd_restore),
      .cmd_rett(cmd_rett), .cmd_wrstat(cmd_wrstat),
      .wr_status(wr_status), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .cwp(cwp), .wim(wim), .et(et), .sup(sup), .prev_sup(prev_sup),
      .status_word(status_word), .trap_valid(trap_valid), .trap_type(trap_type)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after the capture edge
   task automatic drive(input logic s, input logic r, input logic t, input logic w,
                        input logic [31:0] d, input logic mwe, input logic [NW-1:0] md);
      cmd_save = s; cmd_restore = r; cmd_rett = t; cmd_wrstat = w;
      wr_status = d; mask_we = mwe; mask_wdata = md;
      @(posedge clk);
      @(negedge clk);
      cmd_save = 1'b0; cmd_restore = 1'b0; cmd_rett = 1'b0; cmd_wrstat = 1'b0;
      wr_status = '0; mask_we = 1'b0; mask_wdata = '0;
   endtask

   function automatic string op_tag(input logic [2:0] op);
      case (op)
         3'd1:    return "R2/R4 save";
         3'd2:    return "R3/R4 restore";
         3'd3:    return "R5/R6 rett";
         3'd4:    return "R7/R8 status write";
         default: return "R10 mask write";
      endcase
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_P * 50000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cwp", 32'(cwp), 32'h0);
      chk("R1 wim", 32'(wim), 32'h0);
      chk("R1 status_word", status_word, 32'h80);
      chk("R1 trap_valid", 32'(trap_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {status_word[31:1], trap_valid}, 32'h80);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i].op == 3'd1, VEC[i].op == 3'd2, VEC[i].op == 3'd3, VEC[i].op == 3'd4,
               VEC[i].data, VEC[i].op == 3'd5, VEC[i].data[NW-1:0]);
         chk({op_tag(VEC[i].op), " cwp"},  32'(cwp),        32'(VEC[i].cwp));
         chk({op_tag(VEC[i].op), " trap"}, 32'(trap_valid), 32'(VEC[i].trap));
         chk({op_tag(VEC[i].op), " type"}, 32'(trap_type),  32'(VEC[i].tt));
         chk({op_tag(VEC[i].op), " et"},   32'(et),         32'(VEC[i].et));
         chk({op_tag(VEC[i].op), " sup"},  32'(sup),        32'(VEC[i].sup));
      end

      // R8 full field load and readback, upper bits dropped
      drive(1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_1EE2, 1'b0, '0);
      chk("R8 status_word", status_word, 32'h0000_1EE2);
      chk("R8 prev_sup", 32'(prev_sup), 32'h1);
      chk("R8 cwp", 32'(cwp), 32'h2);

      // R9 no trap when idle
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R9 idle trap_valid", 32'(trap_valid), 32'h0);
      chk("R9 idle trap_type", 32'(trap_type), 32'h0);

      // R11 restore beats save
      drive(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R11 restore over save", 32'(cwp), 32'h3);
      // R11 status write beats rett and save
      drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h45, 1'b0, '0);
      chk("R11 write over rett cwp", 32'(cwp), 32'h5);
      chk("R11 write over rett trap", 32'(trap_valid), 32'h0);
      chk("R11 write over rett et", 32'(et), 32'h0);

      // R10 same-cycle mask write uses previous mask
      drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, 8'h40);
      chk("R10 old mask used", 32'(cwp), 32'h6);
      chk("R10 mask loaded", 32'(wim), 32'h40);
      drive(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R2 save after mask", 32'(cwp), 32'h5);
      drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R4 new mask blocks", {trap_type, 24'(cwp)}, {8'h06, 24'h5});

      // R7 boundary: field equal to NWIN
      drive(1'b0, 1'b0, 1'b0, 1'b1, 32'h08, 1'b0, '0);
      chk("R7 field==NWIN trap", {24'(trap_valid), trap_type}, {24'h1, 8'h02});
      chk("R7 field==NWIN cwp", 32'(cwp), 32'h5);
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R9 pulse ends", 32'(trap_valid), 32'h0);

      summary();
      $finish;
   end

endmodule